// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Cache

This block sits between a processor and main memory. It serves word reads and writes on a 15-bit word address with 12-bit data. The storage has 512 sets, and each set holds two ways. A way holds a tag, a data word and a valid flag. On a read, the block looks up the set picked by the address. It compares the tag against both ways and returns the stored word when either way matches. When neither way matches, the block fetches the word from main memory, returns it and keeps a copy. Every write goes straight through to main memory. The cached copy is refreshed only when the address is already present.

After reset the block sweeps through all sets and marks every way empty. The processor side is held not-ready during the sweep. Each set carries one recency bit. The block uses that bit to pick which way to evict once both ways hold valid entries. The processor port and the memory port each use a plain request/ready handshake. Only one access is outstanding at a time, so a request that needs memory stalls the processor until memory finishes.

Top module: `sa2_cache`

## Requirements
- R1: The address bits [8:0] select the set and bits [14:9] form the tag. Addresses that share bits [8:0] compete for the same two ways. Addresses with different set bits never disturb each other.
- R2: After reset is released, `cpuReady` stays low for exactly 512 clock cycles and no memory request is made. When the sweep ends every way is invalid, so the first read of any address misses.
- R3: A read that matches a valid way in either position gives a response in the cycle after acceptance. The response has `cpuHit`=1 and carries the stored word, and no memory request is made.
- R4: A read miss issues exactly one memory read of the request address. In the cycle after `memReady`, it responds with `cpuHit`=0 and the memory word, and it keeps that word with its tag in the set.
- R5: On a miss into a set that still has an invalid way, the new entry goes into the invalid way. Two different tags in one set are therefore both kept.
- R6: When both ways of a set are valid, a miss evicts the way that was least recently hit or filled. The other way stays resident.
- R7: Every accepted write issues one memory write carrying the request address and data. The response follows in the cycle after `memReady`, and its `cpuHit` tells whether the address was cached.
- R8: A write that hits replaces the cached word, so a later read hits with the new data. A write that misses allocates nothing, so a later read of that address misses.
- R9: From the acceptance of a miss or a write until its response, `cpuReady` is low and the memory request holds its address steady. Repeating the same read after a fill hits without a second memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; starts the invalidation sweep |
| cpuReq | input | 1 | Processor request; accepted on a clock edge where `cpuReady` is high |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 15 | Word address: tag in [14:9], set in [8:0] |
| cpuWData | input | 12 | Write data |
| cpuReady | output | 1 | Block can accept a request this cycle |
| cpuRespValid | output | 1 | One-cycle pulse that completes an accepted request |
| cpuHit | output | 1 | With `cpuRespValid`: the address was found in the cache |
| cpuRData | output | 12 | With `cpuRespValid` for a read: the word read |
| memReq | output | 1 | Memory access pending |
| memWe | output | 1 | Pending memory access is a write |
| memAddr | output | 15 | Memory word address |
| memWData | output | 12 | Memory write data |
| memReady | input | 1 | Memory completes the pending access at this clock edge |
| memRData | input | 12 | Memory read data, valid with `memReady` on a read |

## Verification
Some properties are checked on every cycle. Ready stays low through the 512-cycle sweep and during any memory access. A pending memory request keeps its address and direction stable. Each accepted write produces a memory write with the request's address and data. A completed memory read turns into a miss response that carries the memory word. A response never overlaps a memory request. Other behaviour depends on stored contents over several accesses, and only the bench's directed scenarios show it. This includes which way is evicted once a set is full, whether both tags in a set stay resident, whether a write hit updates the copy while a write miss leaves no entry, and whether the set bits and tag bits are split as specified.

// File: rtl/sa2c_pkg.sv
package sa2c_pkg;

  // Per-cycle strobes from the sequencer to the storage datapath.
  typedef struct packed {
    logic capture;      // latch the processor request
    logic useReq;       // look up the latched address instead of the port address
    logic clearSet;     // sweep: invalidate both ways of initIdx
    logic fill;         // install memory data into the victim way
    logic writeHit;     // write port data into the matching way, if any
    logic touch;        // mark the matching way as most recently used
    logic loadHitData;  // capture the matching way's data for the response
    logic loadMemData;  // capture memory data for the response
  } sa2cStrobes_t;

  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_IDLE   = 2'd1,
    ST_RDMISS = 2'd2,
    ST_WRITE  = 2'd3
  } sa2cState_t;

endpackage

// File: rtl/sa2c_datapath.sv
module sa2c_datapath
  import sa2c_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int IDX_W  = 9
) (
  input  logic              clk,
  input  sa2cStrobes_t      strb,
  input  logic [IDX_W-1:0]  initIdx,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWData,
  input  logic [DATA_W-1:0] memRData,
  output logic              lookupHit,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqWData,
  output logic [DATA_W-1:0] respData
);

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;
  localparam int WAYS  = 2;

  logic [ADDR_W-1:0]            reqAddrQ;
  logic [DATA_W-1:0]            reqWDataQ;
  logic [ADDR_W-1:0]            lkAddr;
  logic [IDX_W-1:0]             lkIdx;
  logic [TAG_W-1:0]             lkTag;
  logic [WAYS-1:0]              match;
  logic [WAYS-1:0]              validNow;
  logic [WAYS-1:0][DATA_W-1:0]  rdData;
  logic                         hitWay;
  logic                         victim;
  logic [DATA_W-1:0]            hitData;
  logic [SETS-1:0]              lruArr;   // 1 bit per set: way to evict next

  assign lkAddr = strb.useReq ? reqAddrQ : cpuAddr;
  assign lkIdx  = lkAddr[IDX_W-1:0];
  assign lkTag  = lkAddr[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tagArr  [SETS];
    logic [DATA_W-1:0] dataArr [SETS];
    logic [SETS-1:0]   validArr;
    logic              wayFill;
    logic              wayWrite;

    assign validNow[w] = validArr[lkIdx];
    assign match[w]    = validArr[lkIdx] && (tagArr[lkIdx] == lkTag);
    assign rdData[w]   = dataArr[lkIdx];
    assign wayFill     = strb.fill && (victim == w[0]);
    assign wayWrite    = strb.writeHit && match[w];

    always_ff @(posedge clk) begin
      if (strb.clearSet) begin
        validArr[initIdx] <= 1'b0;
      end else if (wayFill) begin
        validArr[lkIdx] <= 1'b1;
        tagArr[lkIdx]   <= lkTag;
        dataArr[lkIdx]  <= memRData;
      end else if (wayWrite) begin
        dataArr[lkIdx]  <= cpuWData;
      end
    end
  end

  assign lookupHit = |match;
  assign hitWay    = match[1];
  assign hitData   = hitWay ? rdData[1] : rdData[0];

  // Empty ways are filled first; only a full set consults the recency bit.
  always_comb begin
    if (!validNow[0])      victim = 1'b0;
    else if (!validNow[1]) victim = 1'b1;
    else                   victim = lruArr[lkIdx];
  end

  always_ff @(posedge clk) begin
    if (strb.clearSet) begin
      lruArr[initIdx] <= 1'b0;
    end else if (strb.fill) begin
      lruArr[lkIdx] <= ~victim;
    end else if ((strb.writeHit || strb.touch) && lookupHit) begin
      lruArr[lkIdx] <= ~hitWay;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.capture) begin
      reqAddrQ  <= cpuAddr;
      reqWDataQ <= cpuWData;
    end
    if (strb.loadHitData)      respData <= hitData;
    else if (strb.loadMemData) respData <= memRData;
  end

  assign reqAddr  = reqAddrQ;
  assign reqWData = reqWDataQ;

endmodule

// File: rtl/sa2c_control.sv
module sa2c_control
  import sa2c_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpuReq,
  input  logic             cpuWe,
  input  logic             memReady,
  input  logic             lookupHit,
  output sa2cStrobes_t     strb,
  output logic [IDX_W-1:0] initIdx,
  output logic             cpuReady,
  output logic             cpuRespValid,
  output logic             cpuHit,
  output logic             memReq,
  output logic             memWe
);

  sa2cState_t       state;
  sa2cState_t       stateNext;
  logic [IDX_W-1:0] initCnt;
  logic             wrHitQ;
  logic             accept;
  logic             memDone;

  assign accept  = cpuReq && (state == ST_IDLE);
  assign memReq  = (state == ST_RDMISS) || (state == ST_WRITE);
  assign memWe   = (state == ST_WRITE);
  assign memDone = memReq && memReady;
  assign cpuReady = (state == ST_IDLE);
  assign initIdx  = initCnt;

  always_comb begin
    strb          = '0;
    strb.clearSet = (state == ST_INIT);
    strb.useReq   = (state != ST_IDLE);
    if (accept) begin
      strb.capture = 1'b1;
      if (cpuWe) begin
        strb.writeHit = 1'b1;
      end else if (lookupHit) begin
        strb.touch       = 1'b1;
        strb.loadHitData = 1'b1;
      end
    end
    if ((state == ST_RDMISS) && memReady) begin
      strb.fill        = 1'b1;
      strb.loadMemData = 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_INIT:   if (&initCnt) stateNext = ST_IDLE;
      ST_IDLE:   if (accept) begin
                   if (cpuWe)           stateNext = ST_WRITE;
                   else if (!lookupHit) stateNext = ST_RDMISS;
                 end
      ST_RDMISS: if (memReady) stateNext = ST_IDLE;
      ST_WRITE:  if (memReady) stateNext = ST_IDLE;
      default:   stateNext = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_INIT;
      initCnt      <= '0;
      wrHitQ       <= 1'b0;
      cpuRespValid <= 1'b0;
      cpuHit       <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_INIT) initCnt <= initCnt + 1'b1;
      if (accept && cpuWe) wrHitQ <= lookupHit;
      cpuRespValid <= (accept && !cpuWe && lookupHit) || memDone;
      if (accept && !cpuWe)    cpuHit <= lookupHit;
      else if (memDone)        cpuHit <= (state == ST_WRITE) && wrHitQ;
      else                     cpuHit <= 1'b0;
    end
  end

endmodule

// File: rtl/sa2_cache.sv
module sa2_cache
  import sa2c_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int IDX_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWData,
  output logic              cpuReady,
  output logic              cpuRespValid,
  output logic              cpuHit,
  output logic [DATA_W-1:0] cpuRData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRData
);

  sa2cStrobes_t     strb;
  logic [IDX_W-1:0] initIdx;
  logic             lookupHit;

  sa2c_control #(.IDX_W(IDX_W)) u_control (
    .clk          (clk),
    .rst          (rst),
    .cpuReq       (cpuReq),
    .cpuWe        (cpuWe),
    .memReady     (memReady),
    .lookupHit    (lookupHit),
    .strb         (strb),
    .initIdx      (initIdx),
    .cpuReady     (cpuReady),
    .cpuRespValid (cpuRespValid),
    .cpuHit       (cpuHit),
    .memReq       (memReq),
    .memWe        (memWe)
  );

  sa2c_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_datapath (
    .clk       (clk),
    .strb      (strb),
    .initIdx   (initIdx),
    .cpuAddr   (cpuAddr),
    .cpuWData  (cpuWData),
    .memRData  (memRData),
    .lookupHit (lookupHit),
    .reqAddr   (memAddr),
    .reqWData  (memWData),
    .respData  (cpuRData)
  );

endmodule

// File: rtl/sa2_cache_chk.sv
module sa2_cache_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int IDX_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [DATA_W-1:0] cpuWData,
  input logic              cpuReady,
  input logic              cpuRespValid,
  input logic              cpuHit,
  input logic [DATA_W-1:0] cpuRData,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWData,
  input logic              memReady,
  input logic [DATA_W-1:0] memRData
);

  localparam int SETS = 1 << IDX_W;

  logic [IDX_W:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst)                          sinceRst <= '0;
    else if (sinceRst != (IDX_W+1)'(SETS)) sinceRst <= sinceRst + 1'b1;
  end

  // R2: no acceptance and no memory traffic during the sweep
  a_r2_sweep_not_ready: assert property (@(posedge clk) disable iff (rst)
    (sinceRst < (IDX_W+1)'(SETS)) |-> (!cpuReady && !memReq));

  // R9: processor is stalled while memory is busy
  a_r9_stall_on_mem: assert property (@(posedge clk) disable iff (rst)
    memReq |-> !cpuReady);

  // R9: pending memory request holds steady until completed
  a_r9_mem_stable: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R7: each accepted write goes to memory with its address and data
  a_r7_write_through: assert property (@(posedge clk) disable iff (rst)
    (cpuReq && cpuReady && cpuWe) |=>
      (memReq && memWe && memAddr == $past(cpuAddr) && memWData == $past(cpuWData)));

  // R4: a completed memory read becomes a miss response with the memory word
  a_r4_miss_resp: assert property (@(posedge clk) disable iff (rst)
    (memReq && memReady && !memWe) |=>
      (cpuRespValid && !cpuHit && cpuRData == $past(memRData)));

  // R3: a response never coincides with an outstanding memory access
  a_r3_resp_no_mem: assert property (@(posedge clk) disable iff (rst)
    cpuRespValid |-> !memReq);

endmodule

bind sa2_cache sa2_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
  .cpuWData(cpuWData), .cpuReady(cpuReady), .cpuRespValid(cpuRespValid),
  .cpuHit(cpuHit), .cpuRData(cpuRData), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memWData(memWData), .memReady(memReady), .memRData(memRData)
);

// File: tb/sa2_cache_bench.sv
module sa2_cache_bench;

  localparam int ADDR_W = 15;
  localparam int DATA_W = 12;
  localparam int IDX_W  = 9;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpuReq = 1'b0;
  logic              cpuWe = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWData = '0;
  logic              cpuReady;
  logic              cpuRespValid;
  logic              cpuHit;
  logic [DATA_W-1:0] cpuRData;
  logic              memReq;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWData;
  logic              memReady;
  logic [DATA_W-1:0] memRData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sa2_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_sa2_cache (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWData(cpuWData), .cpuReady(cpuReady), .cpuRespValid(cpuRespValid),
    .cpuHit(cpuHit), .cpuRData(cpuRData), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWData(memWData), .memReady(memReady), .memRData(memRData)
  );

  // ---------------- main memory model ----------------
  function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
    return DATA_W'(a * 5 + 12'h3a1) ^ DATA_W'(a >> 3);
  endfunction

  logic              lastWrValid = 1'b0;
  logic [ADDR_W-1:0] lastWrAddr = '0;
  logic [DATA_W-1:0] lastWrData = '0;
  logic [ADDR_W-1:0] lastRdAddr = '0;
  int                nRd = 0;
  int                nWr = 0;
  int                lat = 0;

  assign memRData = (lastWrValid && memAddr == lastWrAddr) ? lastWrData : pat(memAddr);

  always @(posedge clk) begin
    if (rst) begin
      memReady <= 1'b0;
      lat      <= 0;
    end else if (memReq && !memReady) begin
      if (lat == 2) begin memReady <= 1'b1; lat <= 0; end
      else lat <= lat + 1;
    end else begin
      memReady <= 1'b0;
    end
    if (!rst && memReq && memReady) begin
      if (memWe) begin
        nWr         <= nWr + 1;
        lastWrValid <= 1'b1;
        lastWrAddr  <= memAddr;
        lastWrData  <= memWData;
      end else begin
        nRd        <= nRd + 1;
        lastRdAddr <= memAddr;
      end
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
    return {6'(tag), 9'(idx)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic              rHit;
  logic [DATA_W-1:0] rData;
  int                rLat;
  bit                rStallBad;

  task automatic access(input bit we, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWData = d;
    while (!cpuReady) @(negedge clk);
    @(posedge clk);
    #1 cpuReq = 1'b0;
    rLat = 0;
    rStallBad = 1'b0;
    forever begin
      @(negedge clk);
      rLat++;
      if (cpuRespValid) break;
      if (cpuReady) rStallBad = 1'b1;
    end
    rHit  = cpuHit;
    rData = cpuRData;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_sweep();
    int n = 0;
    bit sawBusy = 1'b0;
    @(negedge clk);
    check(!cpuReady && !cpuRespValid && !memReq, "R2", "outputs in reset",
          {cpuReady, cpuRespValid, memReq}, 0);
    rst = 1'b0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (memReq) sawBusy = 1'b1;
      if (cpuReady || n > 2000) break;
    end
    check(n == 512, "R2", "sweep length", n, 512);
    check(!sawBusy, "R2", "memory request during sweep", sawBusy, 0);
  endtask

  task automatic t_cold_miss();
    int rd0 = nRd;
    access(1'b0, mk(1, 5), '0);
    check(!rHit, "R2", "first read after sweep hit", rHit, 0);
    check(rData == pat(mk(1, 5)), "R4", "miss data", rData, pat(mk(1, 5)));
    check(nRd == rd0 + 1, "R4", "memory reads on miss", nRd - rd0, 1);
    check(lastRdAddr == mk(1, 5), "R4", "miss memory address", lastRdAddr, mk(1, 5));
    check(!rStallBad, "R9", "ready during miss", rStallBad, 0);
  endtask

  task automatic t_repeat_hit();
    int rd0 = nRd;
    access(1'b0, mk(1, 5), '0);
    check(rHit, "R3", "repeat read hit", rHit, 1);
    check(rLat == 1, "R3", "hit latency", rLat, 1);
    check(rData == pat(mk(1, 5)), "R3", "hit data", rData, pat(mk(1, 5)));
    check(nRd == rd0, "R9", "second memory read after fill", nRd - rd0, 0);
  endtask

  task automatic t_two_ways();
    access(1'b0, mk(2, 5), '0);
    check(!rHit, "R5", "second tag first access", rHit, 0);
    access(1'b0, mk(1, 5), '0);
    check(rHit && rData == pat(mk(1, 5)), "R5", "first tag kept", rData, pat(mk(1, 5)));
    access(1'b0, mk(2, 5), '0);
    check(rHit && rData == pat(mk(2, 5)), "R5", "second tag kept", rData, pat(mk(2, 5)));
  endtask

  task automatic t_lru_evict();
    // tag 2 used last; touch tag 1 so tag 2 becomes least recent
    access(1'b0, mk(1, 5), '0);
    access(1'b0, mk(3, 5), '0);
    check(!rHit, "R6", "third tag miss", rHit, 0);
    access(1'b0, mk(1, 5), '0);
    check(rHit, "R6", "recent tag survives", rHit, 1);
    access(1'b0, mk(3, 5), '0);
    check(rHit, "R6", "new tag resident", rHit, 1);
    access(1'b0, mk(2, 5), '0);
    check(!rHit, "R6", "least recent tag evicted", rHit, 0);
  endtask

  task automatic t_index_split();
    access(1'b0, mk(7, 0), '0);
    access(1'b0, mk(7, 511), '0);
    access(1'b0, mk(7, 0), '0);
    check(rHit && rData == pat(mk(7, 0)), "R1", "set 0 entry", rData, pat(mk(7, 0)));
    access(1'b0, mk(7, 511), '0);
    check(rHit && rData == pat(mk(7, 511)), "R1", "set 511 entry", rData, pat(mk(7, 511)));
    access(1'b0, mk(7, 6), '0);
    check(!rHit, "R1", "same tag other set", rHit, 0);
  endtask

  task automatic t_write_hit();
    int wr0 = nWr;
    access(1'b1, mk(7, 0), 12'habc);
    check(rHit, "R7", "write hit flag", rHit, 1);
    check(nWr == wr0 + 1, "R7", "memory writes", nWr - wr0, 1);
    check(lastWrAddr == mk(7, 0) && lastWrData == 12'habc, "R7", "memory write data",
          lastWrData, 12'habc);
    check(!rStallBad, "R9", "ready during write", rStallBad, 0);
    access(1'b0, mk(7, 0), '0);
    check(rHit && rData == 12'habc, "R8", "updated copy", rData, 12'habc);
  endtask

  task automatic t_write_miss();
    int wr0 = nWr;
    int rd0;
    access(1'b1, mk(9, 100), 12'h123);
    check(!rHit, "R7", "write miss flag", rHit, 0);
    check(nWr == wr0 + 1 && lastWrAddr == mk(9, 100), "R7", "write miss to memory",
          lastWrAddr, mk(9, 100));
    rd0 = nRd;
    access(1'b0, mk(9, 100), '0);
    check(!rHit, "R8", "no allocate on write miss", rHit, 0);
    check(rData == 12'h123 && nRd == rd0 + 1, "R8", "read after write miss", rData, 12'h123);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset_sweep();
    t_cold_miss();
    t_repeat_hit();
    t_two_ways();
    t_lru_evict();
    t_index_split();
    t_write_hit();
    t_write_miss();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

endmodule